// File: doc/BRIEF.md
# Serially Programmed Rate and Pulse-Mode Configuration for an Infrared Endec

This block holds the operating settings of an infrared pulse encoder/decoder and produces the 16x oversampling enable that paces the endec's pulse timing. It runs from a 3.6864 MHz clock. Its settings are a bit-rate code, a pulse-width mode and two general-purpose control lines. The host loads them over the serial transmit line, the same line that carries payload data.

To reconfigure, the host raises the programming input and sends one 8N1 character at the rate in effect at that time. The block's own receiver captures the character, drops it if it is malformed or carries a forbidden rate code, and holds it pending. The pending settings replace the active ones only when the programming input falls. Only then does the 16x enable move to the new divisor. A synchronous, active-high reset restores the defaults. A shutdown-style enable output carries the inverse of reset.

Top module: `endec_cfg_top`

## Requirements
- R1: While `rst` is high, and on the cycle after it is sampled high, the settings are rate code 6, fixed-short pulse mode (`short_pulse_o` = 1), and both `user1_n_o` and `user2_n_o` high.
- R2: `pwr_en_o` is the logical inverse of `rst` at all times.
- R3: `tick16_o` is a single-cycle pulse whose period in clocks is set by the active rate code: 0→2, 1→4, 2→6, 3→12, 4→16, 5→18, 6→24, 7→32, 8→48, 9→64, 10→96, 11→128, 12→192. Two ticks never occur on consecutive cycles.
- R4: A programming character is 8N1: a low start bit, then data bits least significant first, then a high stop bit. The data bits map as follows. Bits 3:0 are the rate code. Bit 4 is the pulse mode (1 = fixed short pulse, 0 = 3/16-bit pulse). Bit 5 set drives `user1_n_o` low. Bit 6 set drives `user2_n_o` low. Bit 7 has no effect.
- R5: The receiver samples the transmit line with the 16x enable of the active rate, so a character sent at the active bit period (16 × divisor clocks per bit) is received correctly.
- R6: The visible settings change only as a result of a falling edge on `prog_i`. While `prog_i` stays high they keep their previous values, even after a valid character has arrived.
- R7: A character whose rate code is 13, 14 or 15 is discarded, and the previous settings remain.
- R8: A character whose stop bit is sampled low is discarded, and the previous settings remain.
- R9: If several valid characters arrive in one programming window, the last one is applied.
- R10: A programming window in which no valid character arrives leaves the settings unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 3.6864 MHz reference clock |
| rst | input | 1 | Synchronous reset, active high |
| prog_i | input | 1 | High selects programming mode; the falling edge commits |
| txd_i | input | 1 | Serial transmit line (idle high) carrying the programming character |
| tick16_o | output | 1 | One-cycle enable at 16x the active bit rate |
| rate_o | output | 4 | Active rate code |
| short_pulse_o | output | 1 | Active pulse mode, 1 = fixed short pulse |
| user1_n_o | output | 1 | User control line 1, active low |
| user2_n_o | output | 1 | User control line 2, active low |
| pwr_en_o | output | 1 | Inverse of reset, enables the transceiver supply |

## Verification
`prog_i` passes through a two-stage synchronizer and one edge-detect register, so a commit lands on the third rising edge after the input falls. The bench's monitor reads the settings six falling edges after the fall, which leaves a margin past that edge. The 16x enable is not read at a fixed cycle. The monitor first waits for the tick that ends the count already running, then counts the clocks to the next tick and compares that count with the divisor for the new code. The driver holds every serial bit for exactly 16 × divisor clocks of the active rate. Just before each fall it compares the outputs with the previous expected settings, which checks that nothing took effect early.

// File: rtl/endec_cfg_pkg.sv
package endec_cfg_pkg;

    localparam int OVERSAMPLE = 16;
    localparam int RATE_W     = 4;
    localparam int DIV_W      = 8;
    localparam logic [RATE_W-1:0] DEF_RATE = 4'd6;
    localparam logic [RATE_W-1:0] MAX_RATE = 4'd12;

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic              short_mode;
        logic              user1;
        logic              user2;
    } cfg_t;

    localparam cfg_t CFG_DEFAULT = '{rate: DEF_RATE, short_mode: 1'b1, user1: 1'b0, user2: 1'b0};

    // Clocks per 16x tick for each legal rate code
    function automatic logic [DIV_W-1:0] rate_div(input logic [RATE_W-1:0] code);
        case (code)
            4'd0:    rate_div = 8'd2;
            4'd1:    rate_div = 8'd4;
            4'd2:    rate_div = 8'd6;
            4'd3:    rate_div = 8'd12;
            4'd4:    rate_div = 8'd16;
            4'd5:    rate_div = 8'd18;
            4'd6:    rate_div = 8'd24;
            4'd7:    rate_div = 8'd32;
            4'd8:    rate_div = 8'd48;
            4'd9:    rate_div = 8'd64;
            4'd10:   rate_div = 8'd96;
            4'd11:   rate_div = 8'd128;
            4'd12:   rate_div = 8'd192;
            default: rate_div = 8'd24;
        endcase
    endfunction

    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_HOLD} rx_state_e;

endpackage

// File: rtl/endec_sync.sv
module endec_sync #(
    parameter int   WIDTH   = 1,
    parameter logic RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] meta_q, sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= {WIDTH{RST_VAL}};
            sync_q <= {WIDTH{RST_VAL}};
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign dout = sync_q;
endmodule

// File: rtl/endec_baud.sv
module endec_baud
    import endec_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } baud_t;

    baud_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == '0) st_d.cnt = rate_div(rate) - 1'b1;
        else                st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q.cnt <= rate_div(DEF_RATE) - 1'b1;
        else     st_q     <= st_d;
    end

    assign tick = (st_q.cnt == '0);
endmodule

// File: rtl/endec_cfg_rx.sv
module endec_cfg_rx
    import endec_cfg_pkg::*;
#(
    parameter int OS = OVERSAMPLE
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       tick,
    input  logic       line,
    output logic       ok,
    output logic [7:0] data
);
    localparam int TW   = $clog2(OS);
    localparam int HALF = OS / 2;

    typedef struct packed {
        rx_state_e   st;
        logic [TW-1:0] tcnt;
        logic [2:0]  bcnt;
        logic [7:0]  shreg;
        logic        ok;
        logic [7:0]  data;
    } rx_t;

    rx_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.ok = 1'b0;
        if (!en) begin
            r_d.st = RX_IDLE;
        end else if (tick) begin
            case (r_q.st)
                RX_IDLE: begin
                    if (!line) begin
                        r_d.st   = RX_START;
                        r_d.tcnt = '0;
                    end
                end
                RX_START: begin
                    if (r_q.tcnt == TW'(HALF - 1)) begin
                        r_d.tcnt = '0;
                        r_d.bcnt = '0;
                        r_d.st   = line ? RX_IDLE : RX_DATA;
                    end else begin
                        r_d.tcnt = r_q.tcnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (r_q.tcnt == TW'(OS - 1)) begin
                        r_d.tcnt  = '0;
                        r_d.shreg = {line, r_q.shreg[7:1]};
                        if (r_q.bcnt == 3'd7) r_d.st   = RX_STOP;
                        else                  r_d.bcnt = r_q.bcnt + 1'b1;
                    end else begin
                        r_d.tcnt = r_q.tcnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (r_q.tcnt == TW'(OS - 1)) begin
                        if (line) begin
                            r_d.ok   = 1'b1;
                            r_d.data = r_q.shreg;
                            r_d.st   = RX_IDLE;
                        end else begin
                            r_d.st = RX_HOLD;
                        end
                    end else begin
                        r_d.tcnt = r_q.tcnt + 1'b1;
                    end
                end
                default: begin
                    if (line) r_d.st = RX_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q    <= '0;
            r_q.st <= RX_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign ok   = r_q.ok;
    assign data = r_q.data;
endmodule

// File: rtl/endec_cfg_top.sv
module endec_cfg_top
    import endec_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_i,
    input  logic              txd_i,
    output logic              tick16_o,
    output logic [RATE_W-1:0] rate_o,
    output logic              short_pulse_o,
    output logic              user1_n_o,
    output logic              user2_n_o,
    output logic              pwr_en_o
);
    typedef struct packed {
        logic prog_p;
        cfg_t act;
        cfg_t pend;
        logic pend_vld;
    } top_t;

    top_t t_d, t_q;

    logic       prog_s, line_s, rx_ok, commit;
    logic [7:0] rx_data;

    endec_sync #(.WIDTH(1), .RST_VAL(1'b0)) u_sync_prog (
        .clk(clk), .rst(rst), .din(prog_i), .dout(prog_s));

    endec_sync #(.WIDTH(1), .RST_VAL(1'b1)) u_sync_line (
        .clk(clk), .rst(rst), .din(txd_i), .dout(line_s));

    endec_baud u_baud (
        .clk(clk), .rst(rst), .rate(t_q.act.rate), .tick(tick16_o));

    endec_cfg_rx #(.OS(OVERSAMPLE)) u_rx (
        .clk(clk), .rst(rst), .en(prog_s), .tick(tick16_o),
        .line(line_s), .ok(rx_ok), .data(rx_data));

    assign commit = t_q.prog_p & ~prog_s;

    always_comb begin
        t_d        = t_q;
        t_d.prog_p = prog_s;
        if (prog_s && !t_q.prog_p) t_d.pend_vld = 1'b0;
        if (rx_ok && (rx_data[3:0] <= MAX_RATE)) begin
            t_d.pend.rate       = rx_data[3:0];
            t_d.pend.short_mode = rx_data[4];
            t_d.pend.user1      = rx_data[5];
            t_d.pend.user2      = rx_data[6];
            t_d.pend_vld        = 1'b1;
        end
        if (commit && t_q.pend_vld) begin
            t_d.act      = t_q.pend;
            t_d.pend_vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            t_q.prog_p   <= 1'b0;
            t_q.act      <= CFG_DEFAULT;
            t_q.pend     <= CFG_DEFAULT;
            t_q.pend_vld <= 1'b0;
        end else begin
            t_q <= t_d;
        end
    end

    assign rate_o        = t_q.act.rate;
    assign short_pulse_o = t_q.act.short_mode;
    assign user1_n_o     = ~t_q.act.user1;
    assign user2_n_o     = ~t_q.act.user2;
    assign pwr_en_o      = ~rst;
endmodule

// File: rtl/endec_cfg_chk.sv
module endec_cfg_chk
    import endec_cfg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              commit,
    input logic              rx_ok,
    input logic [7:0]        rx_data,
    input cfg_t              pend,
    input logic [RATE_W-1:0] rate,
    input logic              short_mode,
    input logic              u1_n,
    input logic              u2_n
);
    assert_defaults_R1: assert property (@(posedge clk)
        rst |=> (rate == DEF_RATE && short_mode && u1_n && u2_n));

    assert_tick_single_R3: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    assert_hold_until_fall_R6: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable({rate, short_mode, u1_n, u2_n}));

    assert_forbidden_dropped_R7: assert property (@(posedge clk) disable iff (rst)
        (rx_ok && rx_data[3:0] > MAX_RATE) |=> $stable(pend));

    assert_last_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (rx_ok && rx_data[3:0] <= MAX_RATE) |=>
            (pend == {$past(rx_data[3:0]), $past(rx_data[4]), $past(rx_data[5]), $past(rx_data[6])}));
endmodule

bind endec_cfg_top endec_cfg_chk u_chk (
    .clk(clk), .rst(rst), .tick(tick16_o), .commit(commit),
    .rx_ok(rx_ok), .rx_data(rx_data), .pend(t_q.pend),
    .rate(rate_o), .short_mode(short_pulse_o),
    .u1_n(user1_n_o), .u2_n(user2_n_o));

// File: tb/sim_endec_cfg_top.sv
module sim_endec_cfg_top;
    typedef struct {
        int rate;
        int shortm;
        int u1n;
        int u2n;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic prog = 1'b0;
    logic txd = 1'b1;
    logic tick;
    logic [3:0] rate;
    logic shortm, u1n, u2n, pwr;

    int total = 0, fails = 0, cyc = 0;
    exp_t cur;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    endec_cfg_top u0 (
        .clk(clk), .rst(rst), .prog_i(prog), .txd_i(txd),
        .tick16_o(tick), .rate_o(rate), .short_pulse_o(shortm),
        .user1_n_o(u1n), .user2_n_o(u2n), .pwr_en_o(pwr));

    function automatic int div_of(input int code);
        case (code)
            0: return 2;    1: return 4;    2: return 6;    3: return 12;
            4: return 16;   5: return 18;   6: return 24;   7: return 32;
            8: return 48;   9: return 64;   10: return 96;  11: return 128;
            default: return 192;
        endcase
    endfunction

    function automatic exp_t apply(input exp_t old, input logic [7:0] b);
        exp_t e;
        if (b[3:0] > 4'd12) return old;
        e.rate = int'(b[3:0]); e.shortm = int'(b[4]);
        e.u1n = b[5] ? 0 : 1;  e.u2n = b[6] ? 0 : 1;
        return e;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic check_cfg(input exp_t e, input string req);
        check(rate == 4'(e.rate),  req, int'(rate), e.rate);
        check(shortm == e.shortm[0], req, int'(shortm), e.shortm);
        check(u1n == e.u1n[0],     req, int'(u1n), e.u1n);
        check(u2n == e.u2n[0],     req, int'(u2n), e.u2n);
    endtask

    task automatic hold_bits(input int nbits);
        repeat (nbits * 16 * div_of(cur.rate)) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic stop);
        txd = 1'b0; hold_bits(1);
        for (int i = 0; i < 8; i++) begin txd = b[i]; hold_bits(1); end
        txd = stop; hold_bits(1);
        txd = 1'b1; hold_bits(2);
    endtask

    task automatic open_win();
        prog = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    task automatic close_win(input exp_t e, input string req);
        check_cfg(cur, {req, " R6 held"});
        prog = 1'b0;
        exp_q.push_back(e);
        cur = e;
        repeat (450) @(negedge clk);
    endtask

    // Monitor: commit is due on the third edge after the fall, sampled at six
    initial begin
        forever begin
            exp_t e;
            int n;
            @(negedge prog);
            repeat (6) @(negedge clk);
            e = exp_q.pop_front();
            check_cfg(e, "R6 R4 commit");
            while (!tick) @(negedge clk);
            @(negedge clk);
            n = 1;
            while (!tick) begin @(negedge clk); n++; end
            check(n == div_of(e.rate), "R3 tick period", n, div_of(e.rate));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            fails++; total++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        exp_t e;
        int n;
        cur = '{rate: 6, shortm: 1, u1n: 1, u2n: 1};
        repeat (5) @(negedge clk);
        check_cfg(cur, "R1 reset");
        check(pwr == 1'b0, "R2 in reset", int'(pwr), 0);
        rst = 1'b0;
        @(negedge clk);
        check(pwr == 1'b1, "R2 out of reset", int'(pwr), 1);
        while (!tick) @(negedge clk);
        @(negedge clk); n = 1;
        while (!tick) begin @(negedge clk); n++; end
        check(n == 24, "R3 default period", n, 24);

        // R4: 0x16 -> code 6 short mode
        open_win(); send_byte(8'h16, 1'b1); close_win(apply(cur, 8'h16), "R4");
        // R4: 0x36 sets user1
        open_win(); send_byte(8'h36, 1'b1); close_win(apply(cur, 8'h36), "R4");
        // R4: bit7 ignored, 0x96 acts as 0x16
        open_win(); send_byte(8'h96, 1'b1); close_win(apply(cur, 8'h16), "R4 bit7");
        // R6: check outputs still old after byte while prog high
        open_win(); send_byte(8'h05, 1'b1);
        repeat (100) @(negedge clk);
        check_cfg(cur, "R6 before fall");
        close_win(apply(cur, 8'h05), "R6");
        // R5: next byte must be at code 5 rate
        open_win(); send_byte(8'h50, 1'b1); close_win(apply(cur, 8'h50), "R5");
        // R7: forbidden code
        open_win(); send_byte(8'h0E, 1'b1); close_win(cur, "R7");
        // R8: bad stop bit
        open_win(); send_byte(8'h0C, 1'b0); close_win(cur, "R8");
        // R10: empty window
        open_win(); repeat (200) @(negedge clk); close_win(cur, "R10");
        // R9: last valid byte wins
        open_win(); send_byte(8'h03, 1'b1); send_byte(8'h4C, 1'b1);
        e = apply(cur, 8'h4C);
        close_win(e, "R9");
        wait (exp_q.size() == 0);
        repeat (500) @(negedge clk);
        // R1: reset mid-operation
        rst = 1'b1;
        @(negedge clk);
        cur = '{rate: 6, shortm: 1, u1n: 1, u2n: 1};
        check_cfg(cur, "R1 mid reset");
        check(pwr == 1'b0, "R2 mid reset", int'(pwr), 0);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule